// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Alignment Unit

This unit sits between a processor's memory-instruction stage and a simple 32-bit word-wide data memory. For each request it adds a sign-extended 16-bit displacement to a 32-bit base value to form a byte address. It then presents the word-aligned address to memory, and it works out which byte lanes an 8-, 16- or 32-bit access touches under the byte ordering selected for that request. Big-endian or little-endian ordering is chosen per request.

Stores leave the unit with their data already moved into the correct lanes and a matching per-lane write-enable mask. Loads read the whole word. In the following cycle the unit extracts the addressed bytes and zero-extends or sign-extends them to 32 bits. An access whose address does not suit its size raises an address-error flag in the same cycle, and the unit then neither writes to nor reads from memory. No translation happens here: the physical address is the effective address.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, with wrap-around modulo 2^32. While `req_valid` is high, `mem_addr` equals that address with bits 1:0 cleared.
- R2: `req_size` codes are 00 = byte, 01 = halfword, 10 or 11 = word. `addr_err` is high in the same cycle as a valid request when either a halfword address has bit 0 set or a word address has bits 1:0 non-zero. Byte accesses never raise it.
- R3: On an address error, `mem_we` is 0000 and `mem_re` is low, whether the request is a load or a store. No `ld_valid` follows in the next cycle, and memory contents are unchanged.
- R4: Lane k of the word is bits 8k+7:8k. With `big_endian` = 1, byte address offset o within the word maps to lane 3-o; with `big_endian` = 0 it maps to lane o. An aligned store drives `mem_we` high for exactly the lanes of the bytes it covers.
- R5: An aligned store places its datum so that with `big_endian` = 1 the most significant byte sits at the lowest address, and with `big_endian` = 0 the least significant byte does. Bits of `store_data` above the access size are ignored, and `mem_wdata` lanes that are not written are zero.
- R6: An aligned load raises `mem_re` in its request cycle and keeps `mem_we` at 0000.
- R7: `mem_rdata` is the word read in the cycle after `mem_re`. In that cycle `ld_valid` is high and `ld_data` holds the loaded value, assembled with the byte ordering the load was issued under.
- R8: When `req_unsigned` = 0, byte and halfword loads sign-extend to 32 bits. When `req_unsigned` = 1, they zero-extend.
- R9: Byte ordering may change from one request to the next. An aligned word load returns the memory word unchanged in either ordering.
- R10: After reset, `ld_valid` is low. With no valid request, `mem_we`, `mem_re` and `addr_err` are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| big_endian | input | 1 | 1 = big-endian lane mapping for this request |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Store datum, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Word returned one cycle after the read strobe |
| addr_err | output | 1 | Misaligned access exception |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions assume that the request fields only matter while `req_valid` is high. They also assume that `mem_rdata` belongs to the read strobed in the previous cycle, so sign-extension is judged against the size and signedness recorded one cycle earlier. The stimulus meets both assumptions. It applies one request per cycle from the falling clock edge. Its memory model registers read data one cycle after `mem_re` and writes only the enabled lanes. All addresses fall in a 64-byte window that the model covers, reached with both negative displacements and wrap-around bases.

// File: rtl/lsu_align.sv
module lsu_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic        big_endian,
  input  logic [31:0] base,
  input  logic [15:0] offset,
  input  logic [31:0] store_data,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_we,
  output logic [31:0] mem_wdata,
  output logic        mem_re,
  input  logic [31:0] mem_rdata,
  output logic        addr_err,
  output logic        ld_valid,
  output logic [31:0] ld_data
);

  logic [31:0] ea;
  logic        is_word, is_half, misal, go;
  logic [1:0]  span, lane;
  logic [3:0]  mask;
  logic [31:0] sdata;

  assign ea       = base + {{16{offset[15]}}, offset};
  assign mem_addr = {ea[31:2], 2'b00};

  assign is_word  = req_size[1];
  assign is_half  = (req_size == 2'b01);
  assign misal    = (is_half & ea[0]) | (is_word & (|ea[1:0]));
  assign go       = req_valid & ~misal;
  assign addr_err = req_valid & misal;

  assign span  = {is_word, is_word | is_half};
  assign lane  = big_endian ? (2'd3 - ea[1:0] - span) : ea[1:0];
  assign mask  = is_word ? 4'hF : (is_half ? 4'h3 : 4'h1);
  assign sdata = is_word ? store_data :
                 (is_half ? {16'h0, store_data[15:0]} : {24'h0, store_data[7:0]});

  assign mem_we    = (go & req_store) ? (mask << lane) : 4'h0;
  assign mem_wdata = (go & req_store) ? (sdata << {lane, 3'b000}) : 32'h0;
  assign mem_re    = go & ~req_store;

  logic [1:0] lane_q, size_q;
  logic       uns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      lane_q   <= 2'd0;
      size_q   <= 2'd0;
      uns_q    <= 1'b0;
    end else begin
      ld_valid <= mem_re;
      if (mem_re) begin
        lane_q <= lane;
        size_q <= req_size;
        uns_q  <= req_unsigned;
      end
    end
  end

  logic [31:0] raw;
  assign raw = mem_rdata >> {lane_q, 3'b000};

  assign ld_data = size_q[1]         ? raw :
                   (size_q == 2'b01) ? {{16{~uns_q & raw[15]}}, raw[15:0]} :
                                       {{24{~uns_q & raw[7]}},  raw[7:0]};

endmodule

module lsu_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_unsigned,
  input logic [3:0]  mem_we,
  input logic        mem_re,
  input logic        addr_err,
  input logic        ld_valid,
  input logic [31:0] ld_data
);

  a_r3_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (mem_we == 4'h0 && !mem_re));

  a_r3_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> !ld_valid);

  a_r2_byte_never_errs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> !addr_err);

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b00) |-> $countones(mem_we) == 1);

  a_r4_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_store && !addr_err && req_valid && req_size == 2'b01) |-> $countones(mem_we) == 2);

  a_r6_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_we == 4'h0));

  a_r7_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_we == 4'h0 && !mem_re && !addr_err));

  a_r8_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_size == 2'b00 && !req_unsigned) |=>
      (ld_data[31:8] == {24{ld_data[7]}}));

  a_r8_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_size == 2'b00 && req_unsigned) |=> (ld_data[31:8] == 24'h0));

endmodule

bind lsu_align lsu_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .req_unsigned(req_unsigned), .mem_we(mem_we),
  .mem_re(mem_re), .addr_err(addr_err), .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/lsu_align_tb.sv
`timescale 1ns/1ps
module lsu_align_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0, big_endian = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = 32'h0, store_data = 32'h0;
  logic [15:0] offset = 16'h0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_we;
  logic        mem_re, addr_err, ld_valid;
  logic [31:0] rdata = 32'h0;

  always #5 clk = ~clk;

  lsu_align dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .big_endian(big_endian),
    .base(base), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(rdata), .addr_err(addr_err), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  logic [31:0] mem    [16];
  logic [31:0] shadow [16];

  always @(posedge clk) begin
    if (mem_re) rdata <= mem[mem_addr[5:2]];
    for (int k = 0; k < 4; k++)
      if (mem_we[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct { bit present; logic [31:0] val; string tag; } exp_t;
  exp_t q[$];

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(ld_valid == e.present, {e.tag, " ld_valid (R7 R3)"}, {31'h0, ld_valid}, {31'h0, e.present});
      if (e.present && ld_valid)
        chk(ld_data == e.val, {e.tag, " ld_data (R7 R8 R9)"}, ld_data, e.val);
    end else if (rst_n && ld_valid) begin
      chk(1'b0, "R7 unexpected ld_valid", {31'h0, ld_valid}, 32'h0);
    end
  end

  task automatic do_req(input bit st, input logic [1:0] sz, input bit uns, input bit be,
                        input logic [31:0] b, input logic [15:0] off, input logic [31:0] d,
                        input string tag);
    logic [31:0] ea, ew, v;
    logic [3:0]  em;
    int n, o, idx;
    bit mis;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    big_endian = be; base = b; offset = off; store_data = d;
    #1;
    ea  = b + {{16{off[15]}}, off};
    n   = (sz == 2'b00) ? 1 : ((sz == 2'b01) ? 2 : 4);
    o   = int'(ea[1:0]);
    idx = int'(ea[5:2]);
    mis = (n == 2 && ea[0]) || (n == 4 && ea[1:0] != 2'b00);
    chk(mem_addr == {ea[31:2], 2'b00}, {tag, " R1 mem_addr"}, mem_addr, {ea[31:2], 2'b00});
    chk(addr_err == mis, {tag, " R2 addr_err"}, {31'h0, addr_err}, {31'h0, mis});
    em = 4'h0; ew = 32'h0; v = 32'h0;
    if (!mis) begin
      for (int k = 0; k < n; k++) begin
        int dk, ln;
        dk = be ? (n - 1 - k) : k;
        ln = be ? (3 - (o + k)) : (o + k);
        em[ln] = 1'b1;
        ew[8*ln +: 8] = d[8*dk +: 8];
        v[8*dk +: 8]  = shadow[idx][8*ln +: 8];
      end
    end
    if (mis) begin
      chk(mem_we == 4'h0 && !mem_re, {tag, " R3 no access on error"}, {27'h0, mem_re, mem_we}, 32'h0);
      e.present = 1'b0;
    end else if (st) begin
      chk(mem_we == em, {tag, " R4 mem_we"}, {28'h0, mem_we}, {28'h0, em});
      chk(mem_wdata == ew, {tag, " R5 mem_wdata"}, mem_wdata, ew);
      for (int k = 0; k < 4; k++)
        if (em[k]) shadow[idx][8*k +: 8] = ew[8*k +: 8];
      e.present = 1'b0;
    end else begin
      chk(mem_re && mem_we == 4'h0, {tag, " R6 read strobe"}, {27'h0, mem_re, mem_we}, 32'h10);
      if (n == 1) v = uns ? {24'h0, v[7:0]} : {{24{v[7]}}, v[7:0]};
      else if (n == 2) v = uns ? {16'h0, v[15:0]} : {{16{v[15]}}, v[15:0]};
      e.present = 1'b1;
    end
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_store = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'h8091A2B3 + 32'h01010101 * i;
      shadow[i] = 32'h8091A2B3 + 32'h01010101 * i;
    end
    repeat (3) @(negedge clk);
    chk(ld_valid == 1'b0, "R10 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    chk(mem_we == 4'h0 && !mem_re && !addr_err, "R10 reset idle outputs",
        {26'h0, addr_err, mem_re, mem_we}, 32'h0);
    rst_n = 1'b1;
    idle();
    #1;
    chk(mem_we == 4'h0 && !mem_re && !addr_err, "R10 idle after reset",
        {26'h0, addr_err, mem_re, mem_we}, 32'h0);

    // R1 negative displacement and wrap; R9 word in both orders
    do_req(0, 2'b10, 0, 0, 32'h00000040, 16'hFFC4, 32'h0, "R1 R9 LW le neg off");
    do_req(0, 2'b10, 0, 1, 32'h00000040, 16'hFFC4, 32'h0, "R9 LW be same word");
    do_req(0, 2'b10, 0, 1, 32'hFFFFFFF0, 16'h0018, 32'h0, "R1 LW wrap");
    // R4 R8 sub-word loads in both orders
    do_req(0, 2'b00, 0, 0, 32'h00000004, 16'h0001, 32'h0, "R8 LB le o1");
    do_req(0, 2'b00, 1, 1, 32'h00000004, 16'h0001, 32'h0, "R8 LBU be o1");
    do_req(0, 2'b00, 0, 1, 32'h00000004, 16'h0003, 32'h0, "R8 LB be o3");
    do_req(0, 2'b01, 0, 0, 32'h00000008, 16'h0002, 32'h0, "R8 LH le o2");
    do_req(0, 2'b01, 1, 1, 32'h00000008, 16'h0000, 32'h0, "R8 LHU be o0");
    do_req(0, 2'b01, 0, 1, 32'h00000008, 16'h0002, 32'h0, "R8 LH be o2");
    // R4 R5 stores
    do_req(1, 2'b00, 0, 0, 32'h0000000C, 16'h0001, 32'hFFFFFF5A, "R5 SB le o1");
    do_req(1, 2'b00, 0, 1, 32'h0000000C, 16'h0001, 32'h1234566B, "R5 SB be o1");
    do_req(1, 2'b01, 0, 1, 32'h00000010, 16'h0002, 32'hFFFF1234, "R4 SH be o2");
    do_req(1, 2'b01, 0, 0, 32'h00000014, 16'h0000, 32'h0000CAFE, "R4 SH le o0");
    do_req(1, 2'b11, 0, 1, 32'h00000018, 16'h0000, 32'hDEADBEEF, "R5 SW be size11");
    // read back
    do_req(0, 2'b10, 0, 0, 32'h0000000C, 16'h0000, 32'h0, "R5 LW readback 0C");
    do_req(0, 2'b10, 0, 0, 32'h00000010, 16'h0000, 32'h0, "R5 LW readback 10");
    do_req(0, 2'b01, 1, 0, 32'h00000014, 16'h0000, 32'h0, "R8 LHU le readback");
    do_req(0, 2'b01, 0, 0, 32'h00000014, 16'h0000, 32'h0, "R8 LH le readback");
    do_req(0, 2'b00, 0, 1, 32'h00000018, 16'h0000, 32'h0, "R8 LB be readback");
    do_req(0, 2'b00, 0, 0, 32'h00000018, 16'h0000, 32'h0, "R9 LB le after be store");
    // R2 R3 misaligned
    do_req(1, 2'b10, 0, 0, 32'h0000001C, 16'h0002, 32'h01020304, "R3 SW misaligned");
    do_req(1, 2'b01, 0, 1, 32'h0000001C, 16'h0001, 32'h0000AAAA, "R3 SH misaligned");
    do_req(0, 2'b10, 0, 0, 32'h0000001D, 16'h0000, 32'h0, "R3 LW misaligned");
    do_req(0, 2'b01, 0, 1, 32'h0000001F, 16'h0000, 32'h0, "R3 LH misaligned");
    do_req(0, 2'b00, 0, 0, 32'h0000001F, 16'h0000, 32'h0, "R2 LB odd ok");
    do_req(0, 2'b10, 0, 0, 32'h00000020, 16'hFFFC, 32'h0, "R3 LW unchanged after err");
    idle();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule